// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a 64-bit packed-integer arithmetic unit. Each operation views its two operand words as a row of independent lanes: eight 8-bit, four 16-bit or two 32-bit lanes, chosen by a size code. Several operation groups share one datapath:

- lane-wise add and subtract, each in three flavours: wraparound, signed clamping and unsigned clamping;
- per-lane shifts with a common count;
- whole-word bitwise logic;
- equality and signed greater-than tests that return per-lane masks;
- a 16-bit lane multiply and a pairwise multiply-accumulate;
- two narrowing packs that join lanes from both operands.

An operation is presented with `in_valid` together with an opcode, a size code, a shift count and the operands. The result is registered and appears one clock later, flagged by `result_valid`. When no operation is presented, the result register keeps its last value. The block is meant to sit behind an issue stage in a media or signal-processing pipeline. Operand fetch and result write-back belong to the surrounding logic.

Top module: `simd_sat_alu`

## Requirements
- R1: After reset `result` is 0 and `result_valid` is 0. `result_valid` is high exactly in the cycle after a cycle with `in_valid` high. In that cycle `result` carries that operation's value, and `result` is unchanged after a cycle with `in_valid` low.
- R2: Size code 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 select 32-bit lanes; lane i occupies bits [i*W +: W]. Opcode 0 (add) and opcode 3 (subtract, a minus b) wrap modulo 2^W within each lane, and no carry or borrow passes between lanes.
- R3: Opcodes 1 (add) and 4 (subtract) treat lanes as two's-complement. A lane result outside the range clamps to 2^(W-1)-1 or -2^(W-1).
- R4: Opcodes 2 (add) and 5 (subtract) treat lanes as unsigned. An add clamps to 2^W-1, and a subtract below zero gives 0.
- R5: Opcodes 6 (left logical), 7 (right logical) and 8 (right arithmetic) shift every lane of a by `shamt`. A count of W or more gives 0 for 6 and 7, and gives every bit equal to the lane sign for 8.
- R6: Opcodes 9 (a AND b), 10 (NOT a, AND b), 11 (OR) and 12 (XOR) act on the whole word, whatever the size code.
- R7: Opcode 13 (a equal to b) and opcode 14 (a greater than b, signed) set each result lane to all ones when true and to all zeros when false.
- R8: Opcode 15 multiplies the four 16-bit lanes as signed values and keeps the low 16 bits of each product in the lane's place, whatever the size code.
- R9: Opcode 16 forms the signed 16x16 products of lanes 2k and 2k+1 and puts their sum, modulo 2^32, in 32-bit lane k.
- R10: Opcodes 17 and 18 narrow source lanes to half width, 16 to 8 bits for size code 1 and 32 to 16 bits for size codes 2 and 3. The lanes of a fill the low half of the result in order, and those of b fill the high half. Opcode 17 clamps signed to the narrow signed range. Opcode 18 clamps the signed source to 0 through 2^(W/2)-1. Size code 0 gives 0.
- R11: Opcodes 19 to 31 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 5 | Operation code |
| size | input | 2 | Lane width code |
| shamt | input | 8 | Shift count shared by all lanes |
| opa | input | 64 | First operand word |
| opb | input | 64 | Second operand word |
| result | output | 64 | Registered result |
| result_valid | output | 1 | Result register holds a new value |

## Verification
Lane clamping and carry isolation meet in a single operation. One lane overflows and clamps while its neighbour must still produce a plain sum, untouched by the overflowing lane's carry. The bench provokes this with operand words whose lanes alternate between extreme and small values, such as 0x7F01 repeated against 0x0101 repeated. It also sweeps every opcode and size code over corner and pseudo-random words. Every result is judged lane by lane against integer arithmetic computed in the bench.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD     = 5'd0,
      OP_ADD_SS  = 5'd1,
      OP_ADD_US  = 5'd2,
      OP_SUB     = 5'd3,
      OP_SUB_SS  = 5'd4,
      OP_SUB_US  = 5'd5,
      OP_SHL     = 5'd6,
      OP_SHR     = 5'd7,
      OP_SHRA    = 5'd8,
      OP_AND     = 5'd9,
      OP_ANDN    = 5'd10,
      OP_OR      = 5'd11,
      OP_XOR     = 5'd12,
      OP_CMPEQ   = 5'd13,
      OP_CMPGT   = 5'd14,
      OP_MUL     = 5'd15,
      OP_MADD    = 5'd16,
      OP_PACK_SS = 5'd17,
      OP_PACK_US = 5'd18
   } alu_op_e;

   typedef enum logic [1:0] {
      SZ_B     = 2'd0,
      SZ_H     = 2'd1,
      SZ_W     = 2'd2,
      SZ_W_ALT = 2'd3
   } lane_sz_e;

endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith
   import simd_alu_pkg::*;
#(
   parameter int WORD_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [WORD_W-1:0] a_i,
   input  logic [WORD_W-1:0] b_i,
   input  alu_op_e           op_i,
   output logic [WORD_W-1:0] y_o
);
   localparam int NLANE = WORD_W / LANE_W;
   localparam int MSB   = LANE_W - 1;
   localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};
   localparam logic [LANE_W-1:0] ONES = {LANE_W{1'b1}};
   localparam logic [LANE_W-1:0] ZERO = {LANE_W{1'b0}};

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic [LANE_W-1:0] la, lb, lane_y;
      logic [LANE_W:0]   sum, dif;
      logic              sovf_add, sovf_sub;

      assign la  = a_i[g*LANE_W +: LANE_W];
      assign lb  = b_i[g*LANE_W +: LANE_W];
      // carries stay inside the lane: one extra bit per lane, never forwarded
      assign sum = {1'b0, la} + {1'b0, lb};
      assign dif = {1'b0, la} - {1'b0, lb};
      assign sovf_add = (la[MSB] == lb[MSB]) && (sum[MSB] != la[MSB]);
      assign sovf_sub = (la[MSB] != lb[MSB]) && (dif[MSB] != la[MSB]);

      always_comb begin
         case (op_i)
            OP_ADD:    lane_y = sum[LANE_W-1:0];
            OP_ADD_SS: lane_y = sovf_add ? (la[MSB] ? SMIN : SMAX) : sum[LANE_W-1:0];
            OP_ADD_US: lane_y = sum[LANE_W] ? ONES : sum[LANE_W-1:0];
            OP_SUB:    lane_y = dif[LANE_W-1:0];
            OP_SUB_SS: lane_y = sovf_sub ? (la[MSB] ? SMIN : SMAX) : dif[LANE_W-1:0];
            OP_SUB_US: lane_y = dif[LANE_W] ? ZERO : dif[LANE_W-1:0];
            OP_CMPEQ:  lane_y = (la == lb) ? ONES : ZERO;
            OP_CMPGT:  lane_y = ($signed(la) > $signed(lb)) ? ONES : ZERO;
            default:   lane_y = ZERO;
         endcase
      end

      assign y_o[g*LANE_W +: LANE_W] = lane_y;
   end

endmodule

// File: rtl/simd_lane_shift.sv
module simd_lane_shift
   import simd_alu_pkg::*;
#(
   parameter int WORD_W = 64,
   parameter int LANE_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic [WORD_W-1:0] a_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  alu_op_e           op_i,
   output logic [WORD_W-1:0] y_o
);
   localparam int NLANE = WORD_W / LANE_W;
   localparam logic [CNT_W:0] LIM = (CNT_W+1)'(LANE_W);

   logic too_far;
   assign too_far = ({1'b0, cnt_i} >= LIM);

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic [LANE_W-1:0] la, shl, shr, sra, lane_y;

      assign la  = a_i[g*LANE_W +: LANE_W];
      assign shl = la << cnt_i;
      assign shr = la >> cnt_i;
      assign sra = $signed(la) >>> cnt_i;

      always_comb begin
         case (op_i)
            OP_SHL:  lane_y = too_far ? '0 : shl;
            OP_SHR:  lane_y = too_far ? '0 : shr;
            OP_SHRA: lane_y = too_far ? {LANE_W{la[LANE_W-1]}} : sra;
            default: lane_y = '0;
         endcase
      end

      assign y_o[g*LANE_W +: LANE_W] = lane_y;
   end

endmodule

// File: rtl/simd_mulpack.sv
module simd_mulpack
   import simd_alu_pkg::*;
#(
   parameter int WORD_W = 64
) (
   input  logic [WORD_W-1:0] a_i,
   input  logic [WORD_W-1:0] b_i,
   input  alu_op_e           op_i,
   input  lane_sz_e          sz_i,
   output logic [WORD_W-1:0] y_o
);
   localparam int N16 = WORD_W / 16;
   localparam int N32 = WORD_W / 32;

   logic [31:0]       prod [N16];
   logic [WORD_W-1:0] mul_lo, madd, pk_ss, pk_us;

   // signed 16x16 products, one per halfword lane
   for (genvar g = 0; g < N16; g++) begin : g_mul
      logic signed [31:0] ea, eb;
      assign ea      = {{16{a_i[g*16+15]}}, a_i[g*16 +: 16]};
      assign eb      = {{16{b_i[g*16+15]}}, b_i[g*16 +: 16]};
      assign prod[g] = ea * eb;
      assign mul_lo[g*16 +: 16] = prod[g][15:0];
   end

   for (genvar k = 0; k < N32; k++) begin : g_madd
      assign madd[k*32 +: 32] = prod[2*k] + prod[2*k+1];
   end

   // w = 0: 16 -> 8 bits, w = 1: 32 -> 16 bits
   for (genvar w = 0; w < 2; w++) begin : g_pk
      localparam int SW = 16 << w;
      localparam int DW = SW / 2;
      localparam int NS = WORD_W / SW;
      logic [WORD_W-1:0] ss, us;

      for (genvar j = 0; j < 2*NS; j++) begin : g_n
         logic [SW-1:0] src;
         logic          fits;
         if (j < NS) begin : g_src_a
            assign src = a_i[j*SW +: SW];
         end else begin : g_src_b
            assign src = b_i[(j-NS)*SW +: SW];
         end
         assign fits = (src[SW-1:DW-1] == '0) || (src[SW-1:DW-1] == '1);
         assign ss[j*DW +: DW] = fits ? src[DW-1:0]
                               : (src[SW-1] ? {1'b1, {(DW-1){1'b0}}}
                                            : {1'b0, {(DW-1){1'b1}}});
         assign us[j*DW +: DW] = src[SW-1] ? '0
                               : ((|src[SW-2:DW]) ? '1 : src[DW-1:0]);
      end
   end

   always_comb begin
      case (sz_i)
         SZ_B:    begin pk_ss = '0;          pk_us = '0;          end
         SZ_H:    begin pk_ss = g_pk[0].ss;  pk_us = g_pk[0].us;  end
         default: begin pk_ss = g_pk[1].ss;  pk_us = g_pk[1].us;  end
      endcase
   end

   always_comb begin
      case (op_i)
         OP_MUL:     y_o = mul_lo;
         OP_MADD:    y_o = madd;
         OP_PACK_SS: y_o = pk_ss;
         OP_PACK_US: y_o = pk_us;
         default:    y_o = '0;
      endcase
   end

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
   import simd_alu_pkg::*;
#(
   parameter int WORD_W = 64,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [4:0]        opcode,
   input  logic [1:0]        size,
   input  logic [CNT_W-1:0]  shamt,
   input  logic [WORD_W-1:0] opa,
   input  logic [WORD_W-1:0] opb,
   output logic [WORD_W-1:0] result,
   output logic              result_valid
);
   localparam int NWIDTH = 3;

   if (WORD_W < 32 || (WORD_W % 32) != 0) begin : g_bad_word
      $error("simd_sat_alu: WORD_W must be a positive multiple of 32");
   end
   if (CNT_W < 6 || CNT_W > 16) begin : g_bad_cnt
      $error("simd_sat_alu: CNT_W must lie in 6..16");
   end

   alu_op_e           op;
   lane_sz_e          sz;
   logic [WORD_W-1:0] ar_sel, sh_sel, mp_res, nxt;

   assign op = alu_op_e'(opcode);
   assign sz = lane_sz_e'(size);

   // one arithmetic and one shift replica per lane width
   for (genvar s = 0; s < NWIDTH; s++) begin : g_w
      localparam int LW = 8 << s;
      logic [WORD_W-1:0] ar, sh;

      simd_lane_arith #(.WORD_W(WORD_W), .LANE_W(LW)) u_arith (
         .a_i(opa), .b_i(opb), .op_i(op), .y_o(ar)
      );
      simd_lane_shift #(.WORD_W(WORD_W), .LANE_W(LW), .CNT_W(CNT_W)) u_shift (
         .a_i(opa), .cnt_i(shamt), .op_i(op), .y_o(sh)
      );
   end

   always_comb begin
      case (sz)
         SZ_B:    begin ar_sel = g_w[0].ar; sh_sel = g_w[0].sh; end
         SZ_H:    begin ar_sel = g_w[1].ar; sh_sel = g_w[1].sh; end
         default: begin ar_sel = g_w[2].ar; sh_sel = g_w[2].sh; end
      endcase
   end

   simd_mulpack #(.WORD_W(WORD_W)) u_mulpack (
      .a_i(opa), .b_i(opb), .op_i(op), .sz_i(sz), .y_o(mp_res)
   );

   always_comb begin
      case (op)
         OP_ADD, OP_ADD_SS, OP_ADD_US,
         OP_SUB, OP_SUB_SS, OP_SUB_US,
         OP_CMPEQ, OP_CMPGT:               nxt = ar_sel;
         OP_SHL, OP_SHR, OP_SHRA:          nxt = sh_sel;
         OP_AND:                           nxt = opa & opb;
         OP_ANDN:                          nxt = ~opa & opb;
         OP_OR:                            nxt = opa | opb;
         OP_XOR:                           nxt = opa ^ opb;
         OP_MUL, OP_MADD,
         OP_PACK_SS, OP_PACK_US:           nxt = mp_res;
         default:                          nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result       <= '0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= in_valid;
         if (in_valid) result <= nxt;
      end
   end

endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk
   import simd_alu_pkg::*;
#(
   parameter int WORD_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [4:0]        opcode,
   input logic [1:0]        size,
   input logic [WORD_W-1:0] opa,
   input logic [WORD_W-1:0] result,
   input logic              result_valid
);
   localparam int NB = WORD_W / 8;

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> result_valid);

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!result_valid && $stable(result)));

   // R6
   or_covers_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == OP_OR) |=> ((result & $past(opa)) == $past(opa)));

   // R11
   unused_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode > OP_PACK_US) |=> (result == '0));

   for (genvar g = 0; g < NB; g++) begin : g_byte
      // R7
      cmp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode == OP_CMPEQ && size == 2'd0)
         |=> (result[g*8 +: 8] == 8'h00 || result[g*8 +: 8] == 8'hFF));

      // R4
      uadd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode == OP_ADD_US && size == 2'd0)
         |=> (result[g*8 +: 8] >= $past(opa[g*8 +: 8])));

      // R4
      usub_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode == OP_SUB_US && size == 2'd0)
         |=> (result[g*8 +: 8] <= $past(opa[g*8 +: 8])));
   end

endmodule

bind simd_sat_alu simd_sat_alu_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
   .size(size), .opa(opa), .result(result), .result_valid(result_valid)
);

// File: tb/simd_sat_alu_bench.sv
module simd_sat_alu_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  opcode = '0;
   logic [1:0]  size = '0;
   logic [7:0]  shamt = '0;
   logic [63:0] opa = '0, opb = '0;
   logic [63:0] result;
   logic        result_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_sat_alu u_simd_sat_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .size(size), .shamt(shamt), .opa(opa), .opb(opb),
      .result(result), .result_valid(result_valid)
   );

   function automatic longint clampv(longint v, longint lo, longint hi);
      return (v < lo) ? lo : ((v > hi) ? hi : v);
   endfunction

   function automatic longint ufield(logic [63:0] x, int idx, int w);
      longint m = (longint'(1) << w) - 1;
      return longint'(x >> (idx*w)) & m;
   endfunction

   function automatic longint sfield(logic [63:0] x, int idx, int w);
      longint u = ufield(x, idx, w);
      return (u >= (longint'(1) << (w-1))) ? u - (longint'(1) << w) : u;
   endfunction

   function automatic logic [63:0] model(logic [4:0] op, logic [1:0] sz,
                                         logic [7:0] cnt, logic [63:0] a, logic [63:0] b);
      logic [63:0] res = '0;
      int lw = (sz == 2'd0) ? 8 : ((sz == 2'd1) ? 16 : 32);
      longint mx = (longint'(1) << lw) - 1;
      longint smax = mx >> 1;
      longint smin = -smax - 1;
      longint r, ua, ub, sa, sb;
      if (op <= 5'd8 || op == 5'd13 || op == 5'd14) begin
         for (int i = 0; i < 64/lw; i++) begin
            ua = ufield(a, i, lw); ub = ufield(b, i, lw);
            sa = sfield(a, i, lw); sb = sfield(b, i, lw);
            case (op)
               5'd0:  r = ua + ub;
               5'd1:  r = clampv(sa + sb, smin, smax);
               5'd2:  r = clampv(ua + ub, 0, mx);
               5'd3:  r = ua - ub;
               5'd4:  r = clampv(sa - sb, smin, smax);
               5'd5:  r = clampv(ua - ub, 0, mx);
               5'd6:  r = (int'(cnt) >= lw) ? 0 : (ua << cnt);
               5'd7:  r = (int'(cnt) >= lw) ? 0 : (ua >> cnt);
               5'd8:  r = (int'(cnt) >= lw) ? ((sa < 0) ? -1 : 0) : (sa >>> cnt);
               5'd13: r = (ua == ub) ? -1 : 0;
               default: r = (sa > sb) ? -1 : 0;
            endcase
            res |= 64'(r & mx) << (i*lw);
         end
      end else if (op == 5'd9)  res = a & b;
      else if (op == 5'd10) res = ~a & b;
      else if (op == 5'd11) res = a | b;
      else if (op == 5'd12) res = a ^ b;
      else if (op == 5'd15) begin
         for (int i = 0; i < 4; i++) begin
            r = sfield(a, i, 16) * sfield(b, i, 16);
            res |= 64'(r & 64'hFFFF) << (i*16);
         end
      end else if (op == 5'd16) begin
         for (int k = 0; k < 2; k++) begin
            r = sfield(a, 2*k, 16) * sfield(b, 2*k, 16)
              + sfield(a, 2*k+1, 16) * sfield(b, 2*k+1, 16);
            res |= 64'(r & 64'hFFFF_FFFF) << (k*32);
         end
      end else if ((op == 5'd17 || op == 5'd18) && sz != 2'd0) begin
         int sw = (sz == 2'd1) ? 16 : 32;
         int dw = sw / 2;
         int ns = 64 / sw;
         longint dmax = (longint'(1) << dw) - 1;
         for (int j = 0; j < 2*ns; j++) begin
            r = (j < ns) ? sfield(a, j, sw) : sfield(b, j - ns, sw);
            if (op == 5'd17) r = clampv(r, -(dmax >> 1) - 1, dmax >> 1);
            else             r = clampv(r, 0, dmax);
            res |= 64'(r & dmax) << (j*dw);
         end
      end
      return res;
   endfunction

   function automatic string req_of(logic [4:0] op);
      case (op)
         5'd0, 5'd3:             return "R2";
         5'd1, 5'd4:             return "R3";
         5'd2, 5'd5:             return "R4";
         5'd6, 5'd7, 5'd8:       return "R5";
         5'd9, 5'd10, 5'd11, 5'd12: return "R6";
         5'd13, 5'd14:           return "R7";
         5'd15:                  return "R8";
         5'd16:                  return "R9";
         5'd17, 5'd18:           return "R10";
         default:                return "R11";
      endcase
   endfunction

   function automatic logic [63:0] corner(int k);
      case (k % 10)
         0: return 64'h0;
         1: return 64'hFFFF_FFFF_FFFF_FFFF;
         2: return 64'h7F7F_7F7F_7F7F_7F7F;
         3: return 64'h8080_8080_8080_8080;
         4: return 64'h7FFF_8000_0001_FFFE;
         5: return 64'h7F01_7F01_7F01_7F01;
         6: return 64'h0101_0101_0101_0101;
         7: return 64'h8000_0000_7FFF_FFFF;
         8: return 64'h0123_4567_89AB_CDEF;
         default: return 64'hFF00_FF00_00FF_00FF;
      endcase
   endfunction

   function automatic logic [63:0] next_rand(logic [63:0] x);
      logic [63:0] y = x;
      y ^= y << 13; y ^= y >> 7; y ^= y << 17;
      return y;
   endfunction

   task automatic do_op(input logic [4:0] op, input logic [1:0] sz,
                        input logic [7:0] cnt, input logic [63:0] a, input logic [63:0] b);
      logic [63:0] expv;
      expv = model(op, sz, cnt, a, b);
      @(negedge clk);
      in_valid = 1'b1; opcode = op; size = sz; shamt = cnt; opa = a; opb = b;
      @(negedge clk);
      in_valid = 1'b0;
      checks++;
      if (result !== expv || result_valid !== 1'b1) begin
         errors++;
         $display("FAIL %s op=%0d size=%0d cnt=%0d a=%h b=%h actual=%h/%b expected=%h/1",
                  req_of(op), op, sz, cnt, a, b, result, result_valid, expv);
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] held;
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (result !== 64'h0 || result_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset actual=%h/%b expected=0/0", result, result_valid);
      end
      rst_n = 1'b1;

      // R2 R3 R4: alternating saturating and plain lanes in one operation
      do_op(5'd1, 2'd0, 8'd0, 64'h7F01_7F01_7F01_7F01, 64'h0101_0101_0101_0101);
      do_op(5'd2, 2'd0, 8'd0, 64'hFF01_FF01_FF01_FF01, 64'h0101_0101_0101_0101);
      do_op(5'd0, 2'd1, 8'd0, 64'hFFFF_0001_FFFF_0001, 64'h0001_0001_0001_0001);
      do_op(5'd4, 2'd2, 8'd0, 64'h8000_0000_0000_0005, 64'h0000_0001_0000_0007);

      // R1 idle hold: no operation, result must stay put
      held = result;
      @(negedge clk);
      checks++;
      if (result !== held || result_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 idle actual=%h/%b expected=%h/0", result, result_valid, held);
      end

      // full sweep of opcodes, sizes and operand patterns
      for (int op = 0; op < 32; op++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int k = 0; k < 24; k++) begin
               logic [63:0] a, b;
               if (k < 10) begin
                  a = corner(k); b = corner(k * 7 + 3);
               end else begin
                  rng = next_rand(rng); a = rng;
                  rng = next_rand(rng); b = rng;
               end
               do_op(5'(op), 2'(sz), 8'((k * 3) % 41), a, b);
            end
         end
      end

      // R5: every shift count up to past the widest lane
      for (int op = 6; op <= 8; op++) begin
         for (int sz = 0; sz < 3; sz++) begin
            for (int c = 0; c < 42; c++) begin
               rng = next_rand(rng);
               do_op(5'(op), 2'(sz), 8'(c), (c % 2 == 0) ? rng : 64'h8000_8000_8080_8080, 64'h0);
            end
            do_op(5'(op), 2'(sz), 8'd255, 64'hF0F0_8001_7FFF_8000, 64'h0);
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule